// File: doc/BRIEF.md
# Coprocessor Error Interrupt Controller

This block sits between a processor's floating-point error pin and a system controller's legacy interrupt logic. The processor signals a floating-point fault by pulling an active-low error pin low. While error reporting is enabled, the block turns that into a level interrupt request on line 13 of the interrupt controller. Software that wants the processor to continue despite the pending fault writes to I/O port F0h. That write makes the block drive an active-low ignore-error output to the processor.

The ignore-error state can only be set while the error is present. It clears itself as soon as the error pin returns high, and it also clears when reporting is disabled. The error pin is asynchronous and passes through a synchronizer before any use. While reset is held, the ignore-error pin instead presents a frequency-strap value to the processor.

Top module: `cerr_ctrl`

## Requirements
- R1: After reset is released, irq13 is 0 and ignne_n is 1 until an error and a port write occur.
- R2: With reporting enabled, irq13 becomes 1 two clock edges after ferr_n goes low, and returns to 0 two edges after ferr_n goes high.
- R3: While the enable input err_en is 0 (sampled one edge earlier), irq13 stays 0 and ignne_n stays 1 whatever the error pin and port writes do.
- R4: A cycle with io_wr=1 and io_addr=16'h00F0, made while the synchronized error is active and reporting is enabled, drives ignne_n to 0 after the next clock edge.
- R5: A port F0h write made while the error is inactive has no effect, and ignne_n stays 1 when the error later asserts.
- R6: Once asserted, ignne_n stays 0 while the error persists. It returns to 1 in the same cycle irq13 drops, two edges after ferr_n goes high.
- R7: A write to any address other than 16'h00F0 leaves ignne_n at 1.
- R8: While rst_n is 0, ignne_n equals the strap input strap_ignne, and irq13 is 0 after the first edge in reset.
- R9: Clearing err_en while ignne_n is 0 returns ignne_n to 1 and irq13 to 0 one edge later. Re-enabling does not restore the ignore state without a new write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ferr_n | input | 1 | Asynchronous active-low floating-point error from the processor |
| err_en | input | 1 | Error reporting enable from the general control register |
| strap_ignne | input | 1 | Level driven on ignne_n while reset is held |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | Decoded I/O port address of the write |
| irq13 | output | 1 | Level interrupt request, line 13 |
| ignne_n | output | 1 | Active-low ignore-numeric-error to the processor |

## Verification
A stuck or stale synchronizer stage shows up as irq13 rising or falling one edge away from the two-edge latency, on the first error pulse. A lost ignore latch shows as ignne_n staying at 1 after the edge that follows a valid write. A latch that fails to clear shows as ignne_n remaining low once irq13 has dropped, or reappearing after re-enable. The sweep covers every combination of enable, error state and address, so a wrong gate term fails in the first combination that exercises it.

// File: rtl/cerr_pkg.sv
// Shared constants for the coprocessor error interrupt controller.
// Assumes a 16-bit I/O address space and a fixed ignore-error port.
package cerr_pkg;
    localparam int unsigned IO_ADDR_W   = 16;
    localparam logic [IO_ADDR_W-1:0] IGN_PORT = 16'h00F0;
    localparam int unsigned SYNC_DEPTH  = 2;
endpackage

// File: rtl/cerr_sync.sv
// Multi-flop synchronizer for an active-low asynchronous level.
// Assumes the input is glitch-free at the metastability scale; resets to
// the inactive (high) level so no false error is seen after reset.
module cerr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_n,
    output logic q_n
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Each stage samples the one before it, stage 0 samples the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else if (g == 0) chain[g] <= d_n;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_n = chain[STAGES-1];
endmodule

// File: rtl/cerr_ign_latch.sv
// Ignore-error latch: set by a port write while the error is active and
// reporting is enabled, cleared whenever either condition goes away.
// Assumes err_act and en are already in the clock domain.
module cerr_ign_latch #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PORT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_act,
    input  logic              en,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              ign
);
    logic hit;
    logic ign_q;

    // Decode a write to the ignore-error port.
    assign hit = io_wr && (io_addr == PORT);

    // Hold the latch; any loss of error or enable clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)             ign_q <= 1'b0;
        else if (!err_act || !en) ign_q <= 1'b0;
        else if (hit)           ign_q <= 1'b1;
    end

    // Output gated by the live error and enable.
    assign ign = ign_q && err_act && en;

    // R4: the latch only ever sets on the edge after a write strobe
    p_set_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ign_q) |-> $past(io_wr));

    // R5: the latch is never set in a cycle following an inactive error
    p_no_set_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(err_act)) |-> !ign_q);
endmodule

// File: rtl/cerr_ctrl.sv
// Coprocessor error interrupt controller top. Synchronizes the error pin,
// registers the reporting enable, raises irq13 as a level and drives the
// active-low ignore-error pin, which shows the strap value during reset.
// Assumes a synchronous active-low reset held for at least one edge.
module cerr_ctrl
    import cerr_pkg::*;
#(
    parameter int unsigned ADDR_W = IO_ADDR_W,
    parameter logic [ADDR_W-1:0] PORT = IGN_PORT,
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ferr_n,
    input  logic              err_en,
    input  logic              strap_ignne,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              irq13,
    output logic              ignne_n
);
    logic ferr_s_n;
    logic err_act;
    logic en_q;
    logic ign;

    cerr_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_n   (ferr_n),
        .q_n   (ferr_s_n)
    );

    assign err_act = !ferr_s_n;

    // Hold the reporting enable from the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= err_en;
    end

    cerr_ign_latch #(.ADDR_W(ADDR_W), .PORT(PORT)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_act (err_act),
        .en      (en_q),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .ign     (ign)
    );

    // Level interrupt follows the enabled synchronized error.
    always_comb irq13 = err_act && en_q;

    // Strap mux during reset, inverted latch afterwards.
    always_comb ignne_n = rst_n ? !ign : strap_ignne;

    // R3: a cleared enable keeps both outputs quiet
    p_quiet_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(err_en)) |-> (!irq13 && ignne_n));

    // R6: ignore-error is never active without the interrupt
    p_ign_implies_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ignne_n) |-> irq13);

    // R2: the interrupt needs the error pin low two edges earlier
    p_irq_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq13 |-> !$past(ferr_n, 2));
endmodule

// File: tb/cerr_ctrl_tb.sv
module cerr_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ferr_n = 1'b1;
    logic        err_en = 1'b0;
    logic        strap_ignne = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic        irq13;
    logic        ignne_n;

    int tests = 0;
    int fails = 0;

    cerr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ferr_n(ferr_n), .err_en(err_en),
        .strap_ignne(strap_ignne), .io_wr(io_wr), .io_addr(io_addr),
        .irq13(irq13), .ignne_n(ignne_n)
    );

    always #4 clk = ~clk;

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] addrs [3];
        addrs[0] = 16'h00F0; addrs[1] = 16'h00F1; addrs[2] = 16'h01F0;

        // R8: strap mux while reset is held
        strap_ignne = 1'b1; ferr_n = 1'b0; err_en = 1'b1; #1;
        check("R8 strap=1", ignne_n, 1'b1);
        strap_ignne = 1'b0; #1;
        check("R8 strap=0", ignne_n, 1'b0);
        step(3);
        check("R8 irq in reset", irq13, 1'b0);
        ferr_n = 1'b1; err_en = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 irq13", irq13, 1'b0);
        check("R1 ignne_n", ignne_n, 1'b1);

        // Sweep enable x error x address
        for (int en = 0; en < 2; en++) begin
            for (int er = 0; er < 2; er++) begin
                for (int a = 0; a < 3; a++) begin
                    logic exp_ign;
                    err_en = en[0];
                    step(1);
                    ferr_n = !er[0];
                    step(1);
                    check("R2 irq before latency", irq13, 1'b0);
                    step(1);
                    check(en ? "R2 irq asserted" : "R3 irq disabled",
                          irq13, en[0] && er[0]);
                    io_wr = 1'b1; io_addr = addrs[a];
                    step(1);
                    io_wr = 1'b0; io_addr = '0;
                    exp_ign = en[0] && er[0] && (a == 0);
                    check(!en ? "R3 ignne disabled" : (a != 0 ? "R7 other addr" :
                          (er ? "R4 ignne set" : "R5 idle write")),
                          ignne_n, !exp_ign);
                    step(3);
                    check("R6 ignne held", ignne_n, !exp_ign);
                    if (er == 0) begin
                        ferr_n = 1'b0;
                        step(3);
                        check("R5 no late ignore", ignne_n, 1'b1);
                    end
                    ferr_n = 1'b1;
                    step(1);
                    check("R6 ignne before release", ignne_n, !exp_ign);
                    step(1);
                    check("R6 ignne released", ignne_n, 1'b1);
                    check("R2 irq released", irq13, 1'b0);
                    step(1);
                end
            end
        end

        // R9: disable while ignoring, then re-enable
        err_en = 1'b1; ferr_n = 1'b0;
        step(3);
        io_wr = 1'b1; io_addr = 16'h00F0;
        step(1);
        io_wr = 1'b0; io_addr = '0;
        check("R9 setup ignne", ignne_n, 1'b0);
        err_en = 1'b0;
        step(1);
        check("R9 ignne cleared", ignne_n, 1'b1);
        check("R9 irq cleared", irq13, 1'b0);
        err_en = 1'b1;
        step(2);
        check("R9 irq back", irq13, 1'b1);
        check("R9 no restore", ignne_n, 1'b1);
        ferr_n = 1'b1;
        step(3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule